// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one programmable logic cell of the kind that sits inside a fabric of many. A small AND array forms product terms from the cell inputs. Each input is taken true or inverted, or left out, at every crosspoint. The ordinary terms are ORed into one sum. The sum passes through a two-input XOR whose second input is a configuration constant. A configuration bit then picks the cell result: either that combinational value, or the output of a flip-flop that captures it on the global clock.

Three further product terms, built in the same way, drive the flip-flop controls: an asynchronous preset, a synchronous clear and a clock enable. Select bits decide whether the clear comes from its term or from the global clear pin, whether the enable comes from its term or is always active, and whether the preset term is used at all. The configuration word is loaded through a write strobe and is meant to be static while the cell operates. A copy of the result is brought out for routing back into the AND array.

Top module: `pal_macrocell`

## Requirements
- R1: While rst_n is low, the configuration register and the flip-flop are zero. With an all-zero configuration, out_o is 0 for every input value.
- R2: Product term t (0..N_PT+2) is the AND of every input i whose connect bit cfg[t*N_IN+i] is 1. That input is inverted when cfg[NT*N_IN+t*N_IN+i] is 1, where NT=N_PT+3. A term with no connect bit set is 0, and inputs that are not connected have no effect.
- R3: The sum is the OR of terms 0..N_PT-1. With those terms set to a1&b1&c2, !a1&b1&!c2, a1&!b1 and a1&!c2 (a1=in0, b1=in1, c2=in2), the sum follows that equation.
- R4: The XOR constant is mode bit cfg[MB] with MB=2*NT*N_IN. A value of 0 passes the sum unchanged and a value of 1 inverts it.
- R5: Mode bit cfg[MB+1]=0 makes out_o the XOR result within the same cycle. A value of 1 makes out_o the flip-flop, which changes only at a rising clk edge (or on preset).
- R6: Mode bit cfg[MB+3]=1 takes the clock enable from term N_PT+2, and the flip-flop holds while that term is 0. A value of 0 keeps the enable always active.
- R7: The clear is synchronous and forces the flip-flop to 0 even when the enable is inactive. Mode bit cfg[MB+2]=0 takes the clear from term N_PT+1. A value of 1 takes it from gclr. The source not selected is ignored.
- R8: With mode bit cfg[MB+4]=1, term N_PT sets the flip-flop to 1 at once, without a clock edge, and it wins over a clear at the same edge. With the bit at 0, the term is ignored.
- R9: fb_o always equals out_o.
- R10: cfg_data is loaded at a rising clk edge while cfg_wr is 1. The old configuration governs the outputs until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | CFG_W | Configuration word to load |
| in_vec | input | N_IN | Logic inputs to the AND array |
| gclr | input | 1 | Global synchronous clear |
| out_o | output | 1 | Cell result |
| fb_o | output | 1 | Feedback copy of the result |

## Verification
Combinational results (bypass mode, XOR polarity, term wiring) are due in the same cycle as the input change, so the bench drives on the falling edge and checks 1 ns later. Registered results, enable hold and clear are due one rising edge after the stimulus, and are sampled 1 ns after that edge. The preset is checked 1 ns after its input rises, before any edge, to show it is asynchronous. A configuration write is checked both before its loading edge, where the old behaviour must remain, and after it.

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_IN = 4,
  parameter int N_PT = 4,
  localparam int NT = N_PT + 3,
  localparam int PLANE = NT * N_IN,
  localparam int CFG_W = 2 * PLANE + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [N_IN-1:0]  in_vec,
  input  logic             gclr,
  output logic             out_o,
  output logic             fb_o
);
  localparam int MB = 2 * PLANE;

  logic [CFG_W-1:0] cfg_q;
  logic [NT-1:0]    pt;
  logic             q_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_data;

  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [N_IN-1:0] conn, lit;
    assign conn  = cfg_q[t*N_IN +: N_IN];
    assign lit   = in_vec ^ cfg_q[PLANE + t*N_IN +: N_IN];
    assign pt[t] = (|conn) & (&(lit | ~conn));
  end

  logic xor_k, reg_sel, clr_glb, ce_term, pre_en;
  assign {pre_en, ce_term, clr_glb, reg_sel, xor_k} = cfg_q[MB +: 5];

  logic sop, d, pre_hit, clr_now, ce_now;
  assign sop     = |pt[N_PT-1:0];
  assign d       = sop ^ xor_k;
  assign pre_hit = pre_en & pt[N_PT];
  assign clr_now = clr_glb ? gclr : pt[N_PT+1];
  assign ce_now  = ce_term ? pt[N_PT+2] : 1'b1;

  always_ff @(posedge clk or posedge pre_hit or negedge rst_n)
    if (!rst_n)       q_r <= 1'b0;
    else if (pre_hit) q_r <= 1'b1;
    else if (clr_now) q_r <= 1'b0;
    else if (ce_now)  q_r <= d;

  assign out_o = reg_sel ? q_r : d;
  assign fb_o  = out_o;

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_hit && ce_now && !clr_now) |=> (q_r == $past(d) || pre_hit));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_hit && !ce_now && !clr_now) |=> ($stable(q_r) || pre_hit));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_hit && clr_now) |=> (!q_r || pre_hit));
  // R8
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_hit |-> q_r);
endmodule

// File: tb/pal_macrocell_bench.sv
module pal_macrocell_bench;
  localparam int N_IN = 4, N_PT = 4, NT = N_PT + 3;
  localparam int PLANE = NT * N_IN, CFG_W = 2 * PLANE + 5, MB = 2 * PLANE;

  // {in_vec, expected equation value}
  localparam logic [4:0] TBL [16] = '{
    5'b0000_0, 5'b0001_1, 5'b0010_1, 5'b0011_1,
    5'b0100_0, 5'b0101_1, 5'b0110_0, 5'b0111_1,
    5'b1000_0, 5'b1001_1, 5'b1010_1, 5'b1011_1,
    5'b1100_0, 5'b1101_1, 5'b1110_0, 5'b1111_1};

  logic clk = 0, rst_n = 0, cfg_wr = 0, gclr = 0;
  logic [CFG_W-1:0] cfg_data = '0, cw;
  logic [N_IN-1:0] in_vec = '0;
  logic out_o, fb_o;
  int n_chk = 0, n_fail = 0;

  pal_macrocell #(.N_IN(N_IN), .N_PT(N_PT)) u_pal_macrocell (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .in_vec(in_vec), .gclr(gclr), .out_o(out_o), .fb_o(fb_o));

  always #4 clk = ~clk;

  task automatic chk(string req, logic exp);
    n_chk++;
    if (out_o !== exp) begin
      n_fail++;
      $display("FAIL %s: out_o=%b expected %b", req, out_o, exp);
    end
    n_chk++;
    if (fb_o !== out_o) begin
      n_fail++;
      $display("FAIL R9: fb_o=%b expected %b", fb_o, out_o);
    end
  endtask

  task automatic pt(int t, int i, bit inv);
    cw[t*N_IN+i] = 1'b1;
    cw[PLANE+t*N_IN+i] = inv;
  endtask

  task automatic load();
    @(negedge clk); cfg_data = cw; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic step(logic [N_IN-1:0] v, logic g);
    @(negedge clk); in_vec = v; gclr = g;
    @(posedge clk); #1;
  endtask

  task automatic eq_cfg(bit k);
    cw = '0;
    pt(0,0,0); pt(0,1,0); pt(0,2,0);
    pt(1,0,1); pt(1,1,0); pt(1,2,1);
    pt(2,0,0); pt(2,1,1);
    pt(3,0,0); pt(3,2,1);
    cw[MB] = k;
  endtask

  initial begin
    #(8*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    in_vec = '1; gclr = 1;
    #13; chk("R1 in reset", 1'b0);
    rst_n = 1; gclr = 0;
    @(negedge clk); #1; chk("R1 empty cfg after reset", 1'b0);

    eq_cfg(0); load();
    for (int n = 0; n < 16; n++) begin
      @(negedge clk); in_vec = TBL[n][4:1]; #1;
      chk("R3 equation (R2 in3 unconnected)", TBL[n][0]);
    end
    eq_cfg(1); load();
    for (int n = 0; n < 16; n++) begin
      @(negedge clk); in_vec = TBL[n][4:1]; #1;
      chk("R4 xor invert", ~TBL[n][0]);
    end

    cw = '0; pt(0,0,0); cw[MB+1] = 1; in_vec = 0; load();
    step(4'b0000, 0);
    @(negedge clk); in_vec = 4'b0001; #1; chk("R5 registered not same cycle", 1'b0);
    @(posedge clk); #1; chk("R5 registered after edge", 1'b1);

    cw[MB+3] = 1; pt(6,1,0); load();
    step(4'b0000, 0); chk("R6 enable low holds", 1'b1);
    step(4'b0010, 0); chk("R6 enable high captures", 1'b0);

    cw = '0; pt(0,0,0); cw[MB+1] = 1; pt(5,2,0); in_vec = 4'b0001; load();
    step(4'b0001, 0); chk("R5 capture one", 1'b1);
    step(4'b0001, 1); chk("R7 gclr ignored when term selected", 1'b1);
    step(4'b0101, 0); chk("R7 clear term", 1'b0);
    cw[MB+3] = 1; pt(6,1,0); load();
    step(4'b0011, 0); chk("R6 set before clear", 1'b1);
    step(4'b0101, 0); chk("R7 clear over disabled enable", 1'b0);

    cw = '0; pt(0,0,0); cw[MB+1] = 1; pt(5,2,0); cw[MB+2] = 1; in_vec = 4'b0001; load();
    step(4'b0001, 0); chk("R5 capture one", 1'b1);
    step(4'b0101, 0); chk("R7 clear term ignored when gclr selected", 1'b1);
    step(4'b0101, 1); chk("R7 global clear", 1'b0);

    cw = '0; pt(0,0,0); cw[MB+1] = 1; cw[MB+2] = 1; cw[MB+4] = 1; pt(4,3,0);
    in_vec = 0; gclr = 0; load();
    step(4'b0000, 0); chk("R8 preset idle", 1'b0);
    @(negedge clk); in_vec = 4'b1000; #1; chk("R8 preset without edge", 1'b1);
    step(4'b1000, 1); chk("R8 preset wins over clear", 1'b1);
    step(4'b0000, 1); chk("R7 clear after preset drops", 1'b0);
    cw[MB+4] = 0; gclr = 0; load();
    step(4'b1000, 0); chk("R8 preset disabled ignored", 1'b0);

    cw = '0; pt(0,0,0); in_vec = 4'b0001; gclr = 0; load();
    @(negedge clk); #1; chk("R5 bypass comb", 1'b1);
    cw = '0; pt(0,0,1);
    cfg_data = cw; cfg_wr = 1; #1; chk("R10 old cfg before edge", 1'b1);
    @(posedge clk); #1; chk("R10 new cfg after edge", 1'b0);
    @(negedge clk); cfg_wr = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule